// File: doc/BRIEF.md
# Two-Level Lookahead Arithmetic and Logic Unit

This block is a purely combinational 16-bit arithmetic and logic unit. It takes two operands and a carry-in. A control bit optionally complements the second operand. A two-bit selector picks what drives the result: the arithmetic sum, a bitwise AND, a bitwise OR, or a caller-supplied pass-through word. A separate sum output always carries the arithmetic result, whatever the selector says. A carry-out is also provided.

Internally, every bit is handled by a slice that emits generate and propagate terms. Four slices feed a first-level lookahead unit, which computes the carries inside a 4-bit group. Four groups feed a second-level lookahead unit, which computes the carries between groups. No adder carry ripples across the full width.

The block has no handshake and holds no state. It has no valid/ready pair, so there is no back-pressure to honour. Outputs follow the inputs after the combinational delay, and the surrounding pipeline registers them as it sees fit. To subtract, the caller sets the complement bit and the carry-in together.

Top module: `cla_alu16`

## Requirements
- R1: With op_i = 2'b00, result_o equals sum_o.
- R2: With op_i = 2'b01, result_o equals a_i AND the effective second operand.
- R3: With op_i = 2'b10, result_o equals a_i OR the effective second operand.
- R4: With op_i = 2'b11, result_o equals pass_i.
- R5: The effective second operand is ~b_i when b_inv_i = 1, and b_i when b_inv_i = 0. This holds for the sum and logic paths alike.
- R6: sum_o equals the low 16 bits of a_i + effective operand + carry_i, for every value of op_i.
- R7: carry_o equals bit 16 of a_i + effective operand + carry_i.
- R8: With b_inv_i = 1 and carry_i = 1, sum_o equals a_i - b_i modulo 2^16, and carry_o is 1 exactly when a_i >= b_i unsigned.
- R9: pass_i has no effect on result_o, sum_o or carry_o when op_i is not 2'b11.
- R10: With all inputs zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand before optional complement |
| carry_i | input | 1 | Carry into bit 0 |
| b_inv_i | input | 1 | Complement the second operand when 1 |
| op_i | input | 2 | 00 sum, 01 AND, 10 OR, 11 pass-through |
| pass_i | input | 16 | Word routed to the result when op_i is 11 |
| result_o | output | 16 | Selected result |
| sum_o | output | 16 | Arithmetic sum, independent of op_i |
| carry_o | output | 1 | Carry out of bit 15 |

## Verification
The embedded checks are immediate assertions evaluated on settled combinational values. They assume every input is a known 0 or 1, so each check is skipped while any input it reads is unknown. The bench drives all inputs to defined values before the first comparison and only changes them on the falling clock edge. The checks also assume that no input changes between two evaluations of the same settle, which follows from single-point driving in the bench tasks.

// File: rtl/cla_alu_pkg.sv
package cla_alu_pkg;
  typedef enum logic [1:0] {
    OP_SUM  = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_PASS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/cla_bit_slice.sv
module cla_bit_slice
  import cla_alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    b_inv_i,
  input  logic    cin_i,
  input  alu_op_e op_i,
  input  logic    pass_i,
  output logic    gen_o,
  output logic    prop_o,
  output logic    sum_o,
  output logic    res_o
);
  logic b_eff;

  assign b_eff  = b_i ^ b_inv_i;
  assign gen_o  = a_i & b_eff;
  assign prop_o = a_i | b_eff;
  assign sum_o  = a_i ^ b_eff ^ cin_i;

  always_comb begin
    unique case (op_i)
      OP_SUM:  res_o = sum_o;
      OP_AND:  res_o = gen_o;
      OP_OR:   res_o = prop_o;
      default: res_o = pass_i;
    endcase
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  // Each carry is the flat sum of products, not a chain
  always_comb begin
    logic acc;
    logic term;
    for (int i = 0; i <= N; i++) begin
      acc = cin_i;
      for (int j = 0; j < i; j++) acc = acc & prop_i[j];
      for (int k = 0; k < i; k++) begin
        term = gen_i[k];
        for (int j = k + 1; j < i; j++) term = term & prop_i[j];
        acc = acc | term;
      end
      carry_o[i] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < N; k++) begin
      term = gen_i[k];
      for (int j = k + 1; j < N; j++) term = term & prop_i[j];
      acc = acc | term;
    end
    grp_gen_o = acc;
  end

  assign grp_prop_o = &prop_i;

  always_comb begin
    if (!$isunknown({gen_i, prop_i, cin_i})) begin
      for (int i = 0; i < N; i++) begin
        // R7
        ripple_equiv_chk: assert (carry_o[i+1] == (gen_i[i] | (prop_i[i] & carry_o[i])))
          else $error("lookahead carry %0d differs from recursive form", i + 1);
      end
      // R7
      group_term_chk: assert (carry_o[N] == (grp_gen_o | (grp_prop_o & cin_i)))
        else $error("group generate/propagate inconsistent with carry out");
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_alu_pkg::*;
#(
  parameter int GRP_W = 4
) (
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             b_inv_i,
  input  logic             cin_i,
  input  alu_op_e          op_i,
  input  logic [GRP_W-1:0] pass_i,
  output logic [GRP_W-1:0] sum_o,
  output logic [GRP_W-1:0] res_o,
  output logic             grp_gen_o,
  output logic             grp_prop_o,
  output logic             cout_o
);
  logic [GRP_W-1:0] gen_w;
  logic [GRP_W-1:0] prop_w;
  logic [GRP_W:0]   carry_w;

  for (genvar i = 0; i < GRP_W; i++) begin : g_slice
    cla_bit_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .b_inv_i (b_inv_i),
      .cin_i   (carry_w[i]),
      .op_i    (op_i),
      .pass_i  (pass_i[i]),
      .gen_o   (gen_w[i]),
      .prop_o  (prop_w[i]),
      .sum_o   (sum_o[i]),
      .res_o   (res_o[i])
    );
  end

  cla_lookahead #(.N(GRP_W)) u_la (
    .gen_i      (gen_w),
    .prop_i     (prop_w),
    .cin_i      (cin_i),
    .carry_o    (carry_w),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
  );

  assign cout_o = carry_w[GRP_W];
endmodule

// File: rtl/cla_alu16.sv
module cla_alu16
  import cla_alu_pkg::*;
#(
  parameter int GRP_W   = 4,
  parameter int NUM_GRP = 4
) (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        carry_i,
  input  logic        b_inv_i,
  input  logic [1:0]  op_i,
  input  logic [15:0] pass_i,
  output logic [15:0] result_o,
  output logic [15:0] sum_o,
  output logic        carry_o
);
  localparam int W = GRP_W * NUM_GRP;

  alu_op_e            op_sel;
  logic [NUM_GRP-1:0] grp_gen;
  logic [NUM_GRP-1:0] grp_prop;
  logic [NUM_GRP-1:0] grp_cout;
  logic [NUM_GRP:0]   grp_carry;
  logic               top_gen;
  logic               top_prop;

  assign op_sel = alu_op_e'(op_i);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    cla_group #(.GRP_W(GRP_W)) u_grp (
      .a_i        (a_i[g*GRP_W +: GRP_W]),
      .b_i        (b_i[g*GRP_W +: GRP_W]),
      .b_inv_i    (b_inv_i),
      .cin_i      (grp_carry[g]),
      .op_i       (op_sel),
      .pass_i     (pass_i[g*GRP_W +: GRP_W]),
      .sum_o      (sum_o[g*GRP_W +: GRP_W]),
      .res_o      (result_o[g*GRP_W +: GRP_W]),
      .grp_gen_o  (grp_gen[g]),
      .grp_prop_o (grp_prop[g]),
      .cout_o     (grp_cout[g])
    );
  end

  cla_lookahead #(.N(NUM_GRP)) u_top_la (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .cin_i      (carry_i),
    .carry_o    (grp_carry),
    .grp_gen_o  (top_gen),
    .grp_prop_o (top_prop)
  );

  assign carry_o = grp_carry[NUM_GRP];

  always_comb begin
    logic [W-1:0] b_eff;
    logic [W:0]   ref_sum;
    if (!$isunknown({a_i, b_i, carry_i, b_inv_i, op_i, pass_i})) begin
      b_eff   = b_inv_i ? ~b_i : b_i;
      ref_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, carry_i};
      // R6
      sum_value_chk: assert (sum_o == ref_sum[W-1:0])
        else $error("sum output disagrees with operand total");
      // R7
      carry_out_chk: assert (carry_o == ref_sum[W])
        else $error("carry output disagrees with operand total");
      // R7
      top_group_chk: assert (carry_o == (top_gen | (top_prop & carry_i)))
        else $error("second-level group terms inconsistent");
      for (int g = 0; g < NUM_GRP; g++) begin
        // R7
        group_handoff_chk: assert (grp_cout[g] == grp_carry[g+1])
          else $error("group %0d carry out differs from lookahead carry", g);
      end
      // R1 R2 R3 R4
      result_select_chk: assert (result_o == ((op_i == 2'b00) ? sum_o :
                                              (op_i == 2'b01) ? (a_i & b_eff) :
                                              (op_i == 2'b10) ? (a_i | b_eff) : pass_i))
        else $error("result does not follow operation select");
    end
  end
endmodule

// File: tb/cla_alu16_tb_top.sv
module cla_alu16_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] a, b, pass;
  logic        cin, binv;
  logic [1:0]  op;
  logic [15:0] result, sum;
  logic        cout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  cla_alu16 dut_i (
    .a_i      (a),
    .b_i      (b),
    .carry_i  (cin),
    .b_inv_i  (binv),
    .op_i     (op),
    .pass_i   (pass),
    .result_o (result),
    .sum_o    (sum),
    .carry_o  (cout)
  );

  task automatic chk(input string req, input string what, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ta, input logic [15:0] tb, input logic tc,
                       input logic tinv, input logic [1:0] top, input logic [15:0] tp);
    @(negedge clk);
    a = ta; b = tb; cin = tc; binv = tinv; op = top; pass = tp;
    #1;
  endtask

  // Reference built from the requirements
  task automatic check_all(input string req);
    logic [15:0] be;
    logic [16:0] tot;
    logic [15:0] exp_res;
    be  = binv ? ~b : b;
    tot = {1'b0, a} + {1'b0, be} + {16'd0, cin};
    case (op)
      2'b00: exp_res = tot[15:0];
      2'b01: exp_res = a & be;
      2'b10: exp_res = a | be;
      default: exp_res = pass;
    endcase
    chk(req, "result", {1'b0, result}, {1'b0, exp_res});
    chk(req, "sum",    {1'b0, sum},    {1'b0, tot[15:0]});
    chk(req, "carry",  {16'd0, cout},  {16'd0, tot[16]});
  endtask

  task automatic t_zero();
    apply(16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 16'h0);
    chk("R10", "result", {1'b0, result}, 17'd0);
    chk("R10", "sum",    {1'b0, sum},    17'd0);
    chk("R10", "carry",  {16'd0, cout},  17'd0);
  endtask

  task automatic t_add();
    apply(16'hFFFF, 16'h0001, 1'b0, 1'b0, 2'b00, 16'h1234);
    chk("R1", "wrap result", {1'b0, result}, 17'd0);
    chk("R7", "wrap carry", {16'd0, cout}, 17'd1);
    apply(16'h8000, 16'h8000, 1'b1, 1'b0, 2'b00, 16'h0);
    chk("R6", "sum", {1'b0, sum}, 17'h00001);
    chk("R7", "carry", {16'd0, cout}, 17'd1);
    apply(16'h0FFF, 16'h0001, 1'b0, 1'b0, 2'b00, 16'h0);
    chk("R1", "group cross", {1'b0, result}, 17'h01000);
    apply(16'hFFFF, 16'h0000, 1'b1, 1'b0, 2'b00, 16'h0);
    chk("R7", "full propagate", {cout, sum}, 17'h10000);
  endtask

  task automatic t_sub();
    apply(16'd100, 16'd30, 1'b1, 1'b1, 2'b00, 16'h0);
    chk("R8", "diff", {cout, sum}, {1'b1, 16'd70});
    apply(16'd30, 16'd100, 1'b1, 1'b1, 2'b00, 16'h0);
    chk("R8", "borrow", {cout, sum}, {1'b0, 16'hFFBA});
    apply(16'h8000, 16'h8000, 1'b1, 1'b1, 2'b00, 16'h0);
    chk("R8", "equal", {cout, sum}, 17'h10000);
    apply(16'h0000, 16'hFFFF, 1'b1, 1'b1, 2'b00, 16'h0);
    chk("R8", "zero minus max", {cout, sum}, 17'h00001);
  endtask

  task automatic t_logic();
    apply(16'hF0F0, 16'hFF00, 1'b0, 1'b0, 2'b01, 16'h0);
    chk("R2", "and", {1'b0, result}, 17'h0F000);
    apply(16'hF0F0, 16'hFF00, 1'b0, 1'b1, 2'b01, 16'h0);
    chk("R5", "and inverted", {1'b0, result}, 17'h000F0);
    apply(16'hF0F0, 16'h0F00, 1'b0, 1'b0, 2'b10, 16'h0);
    chk("R3", "or", {1'b0, result}, 17'h0FFF0);
    apply(16'h0000, 16'h0F00, 1'b0, 1'b1, 2'b10, 16'h0);
    chk("R5", "or inverted", {1'b0, result}, 17'h0F0FF);
  endtask

  task automatic t_pass();
    apply(16'h1111, 16'h2222, 1'b1, 1'b1, 2'b11, 16'hBEEF);
    chk("R4", "pass", {1'b0, result}, 17'h0BEEF);
    for (int o = 0; o < 3; o++) begin
      apply(16'h1357, 16'h2468, 1'b0, 1'b0, o[1:0], 16'h0000);
      begin
        logic [15:0] r0, s0;
        logic        c0;
        r0 = result; s0 = sum; c0 = cout;
        apply(16'h1357, 16'h2468, 1'b0, 1'b0, o[1:0], 16'hFFFF);
        chk("R9", "result ignores pass", {1'b0, result}, {1'b0, r0});
        chk("R9", "sum ignores pass", {cout, sum}, {c0, s0});
      end
    end
  endtask

  task automatic t_sweep();
    logic [15:0] vals [3];
    vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h8000;
    for (int o = 0; o < 4; o++)
      for (int v = 0; v < 4; v++) begin
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 3; j++) begin
            apply(vals[i], vals[j], v[0], v[1], o[1:0], 16'h5A5A);
            check_all("R6");
          end
        for (int r = 0; r < 40; r++) begin
          apply($urandom(), $urandom(), v[0], v[1], o[1:0], $urandom());
          check_all("R5");
        end
      end
  endtask

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; pass = '0; cin = 1'b0; binv = 1'b0; op = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_zero();
    t_add();
    t_sub();
    t_logic();
    t_pass();
    t_sweep();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule